// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns one parallel character into one asynchronous serial frame on an idle-high line. The frame format is set by static inputs: 7 or 8 data bits, no parity or even or odd parity, and 1 or 2 stop bits. A host hands over a character with a single-cycle write strobe while the busy output is low. Busy then stays high until the last stop bit has run its full length.

Bit timing comes from an external tick that pulses once per bit period. The block holds no baud generator of its own. A run enable gates the whole transmitter. While the enable is low, every input is ignored, busy reads 0 and the line is held at 1.

Top module: `uart_frame_tx`

## Requirements
- R1: When `run_en`=1, `busy`=0 and `wr_stb`=1 at a clock edge, `wr_data` is captured and `busy` reads 1 from the next cycle. `line_out` stays 1 until the next `bit_tick`.
- R2: The first `bit_tick` after capture drives a start bit of 0. Each later tick advances one bit. The data bits follow the start bit, least significant bit first, and every bit lasts exactly one tick period.
- R3: With `cfg_eight`=0, only `wr_data[6:0]` is sent and `wr_data[7]` has no effect on the line. With `cfg_eight`=1, all 8 bits are sent.
- R4: With `cfg_par_on`=1, one parity bit follows the data bits. `cfg_par_odd`=0 makes the count of ones in the data bits plus the parity bit even. `cfg_par_odd`=1 makes that count odd.
- R5: With `cfg_par_on`=0, no parity bit is sent and `cfg_par_odd` has no effect.
- R6: The stop bits are 1. `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two. `busy` falls on the tick that ends the last stop bit.
- R7: Whenever `busy` is 0, `line_out` is 1.
- R8: A write strobe while `busy`=1 is ignored and leaves the frame in progress unchanged.
- R9: While `run_en`=0, `busy` is 0 from the next cycle, `line_out` is 1, and strobes are ignored. Dropping `run_en` during a frame abandons that frame.
- R10: While running, `line_out` changes only at an edge where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 enables the transmitter, 0 forces the idle outputs |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cfg_eight | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| cfg_par_on | input | 1 | 1 inserts a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| wr_stb | input | 1 | One-cycle write event |
| wr_data | input | 8 | Character to send |
| busy | output | 1 | High while a frame is pending or being sent |
| line_out | output | 1 | Serial output, idle high |

## Verification
All outputs are registered, so each result appears in the cycle after the edge that caused it:
- `busy` rises one cycle after an accepted strobe.
- `line_out` takes a new bit one cycle after each tick.
- `busy` falls one cycle after the tick that ends the last stop bit.
- Dropping `run_en` takes effect at the next edge.

The bench model updates its expected `busy` and line level on the same rising edges from the same inputs. It compares both against the design on every falling edge, so each comparison falls half a cycle after the edge that is due to produce the value. Stimulus is driven on falling edges, away from the edges the design samples.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          bit_tick,
  input  logic          cfg_eight,
  input  logic          cfg_par_on,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          line_out
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame_q, frame_d;
  logic [CW-1:0] left_q, len_d;
  logic          busy_q, line_q;

  wire [DW-1:0] data_m = cfg_eight ? wr_data : {1'b0, wr_data[DW-2:0]};
  wire          par_bit = (^data_m) ^ cfg_par_odd;
  wire          start = run_en & wr_stb & ~busy_q;

  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (cfg_eight || i < DW - 1) frame_d[i+1] = data_m[i];
    if (cfg_par_on) frame_d[cfg_eight ? DW + 1 : DW] = par_bit;
    len_d = CW'(DW + 2 - (cfg_eight ? 0 : 1) + (cfg_par_on ? 1 : 0) + (cfg_two_stop ? 1 : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      line_q  <= 1'b1;
    end else if (!run_en) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      line_q  <= 1'b1;
    end else if (start) begin
      frame_q <= frame_d;
      left_q  <= len_d;
      busy_q  <= 1'b1;
    end else if (busy_q && bit_tick) begin
      if (left_q != '0) begin
        line_q  <= frame_q[0];
        frame_q <= {1'b1, frame_q[FW-1:1]};
        left_q  <= left_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign line_out = line_q;

  p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wr_stb && !busy) |=> busy);
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);
  p_run_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!busy && line_out));
  p_line_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !bit_tick) |=> $stable(line_out));
  p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && busy && wr_stb && !bit_tick) |=> (busy && $stable(line_out)));
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && busy && !bit_tick) |=> busy);
endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, bit_tick = 1'b0;
  logic cfg_eight = 1'b1, cfg_par_on = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic busy, line_out;

  int checks = 0, fails = 0, cycles = 0, tick_cnt = 0;
  string cur_req = "R7";

  always #10 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
    .cfg_eight(cfg_eight), .cfg_par_on(cfg_par_on), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .wr_stb(wr_stb), .wr_data(wr_data),
    .busy(busy), .line_out(line_out));

  bit   q[$];
  logic m_busy = 1'b0, m_line = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_busy = 1'b0; m_line = 1'b1;
    end else if (!run_en) begin
      q.delete(); m_busy = 1'b0; m_line = 1'b1;
    end else if (m_busy) begin
      if (bit_tick) begin
        if (q.size() > 0) m_line = q.pop_front();
        else begin m_busy = 1'b0; m_line = 1'b1; end
      end
    end else if (wr_stb) begin
      int n, ones;
      n = cfg_eight ? 8 : 7;
      ones = 0;
      q.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
        q.push_back(wr_data[i]);
        ones += wr_data[i];
      end
      if (cfg_par_on)
        q.push_back(cfg_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
      q.push_back(1'b1);
      if (cfg_two_stop) q.push_back(1'b1);
      m_busy = 1'b1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    tick_cnt = (tick_cnt + 1) % 4;
    bit_tick <= (tick_cnt == 0);
    if (rst_n) begin
      checks++;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL %s busy actual=%b expected=%b t=%0t", cur_req, busy, m_busy, $time);
      end
      checks++;
      if (line_out !== m_line) begin
        fails++;
        $display("FAIL %s line actual=%b expected=%b t=%0t", cur_req, line_out, m_line, $time);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  task automatic send(input logic [7:0] d);
    while (busy) @(negedge clk);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fmt(input logic e, input logic p, input logic o, input logic s);
    cfg_eight = e; cfg_par_on = p; cfg_par_odd = o; cfg_two_stop = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || line_out !== 1'b1) begin
      fails++;
      $display("FAIL R7 reset actual=%b%b expected=01", busy, line_out);
    end
    rst_n = 1'b1;
    cur_req = "R9"; wr_data = 8'h55; wr_stb = 1'b1;
    repeat (6) @(negedge clk);
    wr_stb = 1'b0;
    run_en = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R1"; fmt(1, 0, 0, 0); send(8'hA5); drain();
    cur_req = "R2"; send(8'h01); drain();
    cur_req = "R3"; fmt(0, 0, 0, 0); send(8'hD3); drain();
    send(8'h80); drain();
    cur_req = "R4"; fmt(1, 1, 0, 0); send(8'h37); drain();
    fmt(1, 1, 1, 1); send(8'h37); drain();
    fmt(0, 1, 1, 0); send(8'hFF); drain();
    fmt(1, 1, 0, 1); send(8'h00); drain();
    cur_req = "R5"; fmt(1, 0, 1, 0); send(8'h6C); drain();
    cur_req = "R6"; fmt(0, 0, 0, 1); send(8'h2A); drain();
    cur_req = "R8"; fmt(1, 0, 0, 0); send(8'hF0);
    repeat (9) @(negedge clk);
    wr_data = 8'h0F; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    drain();
    cur_req = "R9"; fmt(1, 1, 1, 1); send(8'hC3);
    repeat (14) @(negedge clk);
    run_en = 1'b0;
    repeat (4) @(negedge clk);
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (4) @(negedge clk);
    run_en = 1'b1;
    cur_req = "R10"; fmt(1, 0, 0, 0); send(8'h99); drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule